// File: doc/BRIEF.md
# Receive Descriptor Ring Engine

This block moves received Ethernet frames from a byte stream into memory. Software keeps a ring of receive descriptors, each naming a buffer and its capacity, plus a parallel ring of status entries. For every frame the engine reads the descriptor at the current produce index, writes the frame bytes into that buffer, writes a status entry with the stored length and error flags, and then advances the produce index.

Software reads the produce index to find filled slots and writes the consume index to return them. When no free slot is left, an arriving frame is swallowed whole and counted, and memory is not touched. All sizes follow a "value minus one" encoding: the ring size, the buffer capacity and the reported length.

The memory port is a simple synchronous master. A request is taken on the clock edge where it is high, and read data returns on the next cycle. The byte input is held off with a ready signal while a descriptor is being fetched.

Top module: `rxring_engine`

## Requirements
- R1: After reset the produce index, the consume index, the drop count, both base registers and the ring-size register read 0. `mem_req` and `rx_ready` are low.
- R2: On a start byte with a free slot, the engine reads the word at desc_base + 8*produce (buffer pointer) and then the word at desc_base + 8*produce + 4 (control word). Both reads happen before the first byte is accepted, and no other read occurs for that frame.
- R3: Byte k of a frame is written to the word at pointer + 4*(k/4), in byte lane k mod 4 (lane 0 = bits 7:0). Only the byte enables of written lanes are set. Bytes outside the frame in the buffer are left unchanged.
- R4: Only control bits 10:0 are used, and they hold capacity minus one. Bytes past the capacity are dropped, nothing is written past the capacity, and status bit 28 (overrun) is set.
- R5: Status info is written at stat_base + 8*produce. Bits 10:0 hold the stored length minus one. Bit 23 is set when `rx_err` was high on any byte of the frame. Bit 28 is the overrun flag. All other bits are 0. The next word (+4) is written as 0.
- R6: Both status words are written after the frame's last data write. The produce index changes in the cycle after the second status write, and goes from the ring-size register's value back to 0.
- R7: If (produce+1) mod size equals consume when a start byte arrives, the frame is accepted and discarded with no memory access. The drop count rises by one and the produce index does not change.
- R8: Register map (`reg_addr`): 0 descriptor base, 1 status base, 2 ring size minus one, 3 produce index (read-only), 4 consume index, 5 drop count (read-only). `reg_rdata` shows the register addressed in the previous cycle, and writes to 3 and 5 have no effect.
- R9: Writing the consume index frees slots, so a ring that was full accepts the next frame into the slot at the produce index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, one cycle after address |
| rx_valid | input | 1 | Byte present on rx_data |
| rx_ready | output | 1 | Engine accepts the byte this cycle |
| rx_sof | input | 1 | Byte is the first of a frame |
| rx_eof | input | 1 | Byte is the last of a frame |
| rx_err | input | 1 | Receive error seen on this byte |
| rx_data | input | 8 | Frame byte |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Byte address, word aligned |
| mem_be | output | 4 | Byte enables for writes |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid the cycle after a read request |

## Verification
The assertions rely on the following conditions:
- Every frame starts with a start byte.
- The ring size is programmed before the first frame and not lowered afterwards.
- Buffer pointers are word aligned.
- The memory answers every read on the next cycle.

The stimulus programs the registers once while the input is idle. It always raises `rx_sof` on the first byte and places word-aligned buffers in descriptors, whose control words also carry set bits outside 10:0. The memory model returns read data with a fixed one-cycle latency.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
  localparam int LEN_W       = 11;
  localparam int BIT_FRM_ERR = 23;
  localparam int BIT_OVERRUN = 28;

  localparam logic [2:0] RA_DESC_BASE = 3'd0;
  localparam logic [2:0] RA_STAT_BASE = 3'd1;
  localparam logic [2:0] RA_RING_LAST = 3'd2;
  localparam logic [2:0] RA_PRODUCE   = 3'd3;
  localparam logic [2:0] RA_CONSUME   = 3'd4;
  localparam logic [2:0] RA_DROPS     = 3'd5;

  typedef enum logic [3:0] {
    WS_IDLE,
    WS_FPTR,
    WS_FCTL,
    WS_FWAIT,
    WS_DATA,
    WS_DROP,
    WS_STAT0,
    WS_STAT1,
    WS_ADV
  } wr_state_t;
endpackage

// File: rtl/rxr_regs.sv
module rxr_regs
  import rxr_pkg::*;
#(
  parameter int AW   = 32,
  parameter int IDXW = 8,
  parameter int DCW  = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            reg_wr,
  input  logic [2:0]      reg_addr,
  input  logic [31:0]     reg_wdata,
  output logic [31:0]     reg_rdata,
  input  logic [IDXW-1:0] prod,
  input  logic [DCW-1:0]  drops,
  output logic [AW-1:0]   desc_base,
  output logic [AW-1:0]   stat_base,
  output logic [IDXW-1:0] ring_last,
  output logic [IDXW-1:0] cons
);
  always_ff @(posedge clk) begin
    if (rst) begin
      desc_base <= '0;
      stat_base <= '0;
      ring_last <= '0;
      cons      <= '0;
    end else if (reg_wr) begin
      case (reg_addr)
        RA_DESC_BASE: desc_base <= AW'(reg_wdata);
        RA_STAT_BASE: stat_base <= AW'(reg_wdata);
        RA_RING_LAST: ring_last <= reg_wdata[IDXW-1:0];
        RA_CONSUME:   cons      <= reg_wdata[IDXW-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else begin
      case (reg_addr)
        RA_DESC_BASE: reg_rdata <= 32'(desc_base);
        RA_STAT_BASE: reg_rdata <= 32'(stat_base);
        RA_RING_LAST: reg_rdata <= 32'(ring_last);
        RA_PRODUCE:   reg_rdata <= 32'(prod);
        RA_CONSUME:   reg_rdata <= 32'(cons);
        RA_DROPS:     reg_rdata <= 32'(drops);
        default:      reg_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/rxr_ring.sv
module rxr_ring #(
  parameter int IDXW = 8,
  parameter int DCW  = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [IDXW-1:0] ring_last,
  input  logic [IDXW-1:0] cons,
  input  logic            adv,
  input  logic            drop_evt,
  output logic [IDXW-1:0] prod,
  output logic            full,
  output logic [DCW-1:0]  drops
);
  logic [IDXW-1:0] prod_nxt;

  assign prod_nxt = (prod == ring_last) ? '0 : prod + 1'b1;
  assign full     = (prod_nxt == cons);

  always_ff @(posedge clk) begin
    if (rst) begin
      prod  <= '0;
      drops <= '0;
    end else begin
      if (adv)      prod  <= prod_nxt;
      if (drop_evt) drops <= drops + 1'b1;
    end
  end

  AST_PROD_STEP: assert property (@(posedge clk) disable iff (rst)
    (prod != $past(prod)) |->
      (prod == (($past(prod) == $past(ring_last)) ? '0 : IDXW'($past(prod) + 1'b1)))); // R6

  AST_PROD_RANGE: assert property (@(posedge clk) disable iff (rst)
    prod <= ring_last); // R6

  AST_DROP_HOLDS_PROD: assert property (@(posedge clk) disable iff (rst)
    $past(drop_evt) |-> (prod == $past(prod))); // R7
endmodule

// File: rtl/rxr_writer.sv
module rxr_writer
  import rxr_pkg::*;
#(
  parameter int AW   = 32,
  parameter int IDXW = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            rx_valid,
  output logic            rx_ready,
  input  logic            rx_sof,
  input  logic            rx_eof,
  input  logic            rx_err,
  input  logic [7:0]      rx_data,
  input  logic [AW-1:0]   desc_base,
  input  logic [AW-1:0]   stat_base,
  input  logic [IDXW-1:0] prod,
  input  logic            full,
  output logic            adv,
  output logic            drop_evt,
  output logic            mem_req,
  output logic            mem_we,
  output logic [AW-1:0]   mem_addr,
  output logic [3:0]      mem_be,
  output logic [31:0]     mem_wdata,
  input  logic [31:0]     mem_rdata
);
  wr_state_t        state;
  logic [AW-1:0]    buf_ptr;
  logic [LEN_W-1:0] cap;
  logic [LEN_W-1:0] kidx;
  logic [LEN_W-1:0] len_m1;
  logic             capped;
  logic             ovr;
  logic             ferr;
  logic [31:0]      acc;
  logic [3:0]       acc_be;
  logic [31:0]      new_word;
  logic [3:0]       new_be;
  logic [31:0]      status_word;
  logic [AW-1:0]    slot_off;
  logic             take;
  logic             flush;

  assign rx_ready = (state == WS_DATA) || (state == WS_DROP);
  assign take     = rx_valid && rx_ready;
  assign adv      = (state == WS_ADV);
  assign drop_evt = (state == WS_DROP) && take && rx_eof;
  assign slot_off = AW'({prod, 3'b000});
  assign flush    = (kidx[1:0] == 2'd3) || rx_eof || (kidx == cap);

  always_comb begin
    new_word = acc;
    new_be   = acc_be;
    case (kidx[1:0])
      2'd0: begin new_word[7:0]   = rx_data; new_be[0] = 1'b1; end
      2'd1: begin new_word[15:8]  = rx_data; new_be[1] = 1'b1; end
      2'd2: begin new_word[23:16] = rx_data; new_be[2] = 1'b1; end
      default: begin new_word[31:24] = rx_data; new_be[3] = 1'b1; end
    endcase
  end

  always_comb begin
    status_word = '0;
    status_word[LEN_W-1:0]  = len_m1;
    status_word[BIT_FRM_ERR] = ferr;
    status_word[BIT_OVERRUN] = ovr;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= WS_IDLE;
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_be    <= '0;
      mem_wdata <= '0;
      buf_ptr   <= '0;
      cap       <= '0;
      kidx      <= '0;
      len_m1    <= '0;
      capped    <= 1'b0;
      ovr       <= 1'b0;
      ferr      <= 1'b0;
      acc       <= '0;
      acc_be    <= '0;
    end else begin
      case (state)
        WS_IDLE: begin
          mem_req <= 1'b0;
          if (rx_valid && rx_sof) begin
            if (full) begin
              state <= WS_DROP;
            end else begin
              mem_req  <= 1'b1;
              mem_we   <= 1'b0;
              mem_addr <= desc_base + slot_off;
              state    <= WS_FPTR;
            end
          end
        end
        WS_FPTR: begin
          mem_addr <= mem_addr + AW'(4);
          state    <= WS_FCTL;
        end
        WS_FCTL: begin
          mem_req <= 1'b0;
          buf_ptr <= AW'(mem_rdata);
          state   <= WS_FWAIT;
        end
        WS_FWAIT: begin
          cap    <= mem_rdata[LEN_W-1:0];
          kidx   <= '0;
          capped <= 1'b0;
          ovr    <= 1'b0;
          ferr   <= 1'b0;
          acc    <= '0;
          acc_be <= '0;
          state  <= WS_DATA;
        end
        WS_DATA: begin
          mem_req <= 1'b0;
          if (take) begin
            ferr <= ferr | rx_err;
            if (capped) begin
              ovr <= 1'b1;
            end else begin
              if (flush) begin
                mem_req   <= 1'b1;
                mem_we    <= 1'b1;
                mem_addr  <= buf_ptr + AW'({kidx[LEN_W-1:2], 2'b00});
                mem_wdata <= new_word;
                mem_be    <= new_be;
                acc       <= '0;
                acc_be    <= '0;
              end else begin
                acc    <= new_word;
                acc_be <= new_be;
              end
              if (kidx == cap) capped <= 1'b1;
              else             kidx   <= kidx + 1'b1;
            end
            if (rx_eof) begin
              len_m1 <= kidx;
              state  <= WS_STAT0;
            end
          end
        end
        WS_DROP: begin
          if (take && rx_eof) state <= WS_IDLE;
        end
        WS_STAT0: begin
          mem_req   <= 1'b1;
          mem_we    <= 1'b1;
          mem_be    <= 4'hF;
          mem_addr  <= stat_base + slot_off;
          mem_wdata <= status_word;
          state     <= WS_STAT1;
        end
        WS_STAT1: begin
          mem_addr  <= mem_addr + AW'(4);
          mem_wdata <= '0;
          state     <= WS_ADV;
        end
        WS_ADV: begin
          mem_req <= 1'b0;
          mem_we  <= 1'b0;
          state   <= WS_IDLE;
        end
        default: state <= WS_IDLE;
      endcase
    end
  end

  AST_WRITE_IN_BUFFER: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we && ((state == WS_DATA) || (state == WS_STAT0))) |->
      ((mem_addr - buf_ptr) <= AW'(cap))); // R4

  AST_DROP_QUIET: assert property (@(posedge clk) disable iff (rst)
    (state == WS_DROP) |-> !mem_req); // R7

  AST_NO_BYTE_BEFORE_DESC: assert property (@(posedge clk) disable iff (rst)
    ((state == WS_DATA) && $past(state) != WS_DATA) |-> ($past(state) == WS_FWAIT)); // R2
endmodule

// File: rtl/rxring_engine.sv
module rxring_engine #(
  parameter int AW   = 32,
  parameter int IDXW = 8,
  parameter int DCW  = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_wr,
  input  logic [2:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  input  logic          rx_valid,
  output logic          rx_ready,
  input  logic          rx_sof,
  input  logic          rx_eof,
  input  logic          rx_err,
  input  logic [7:0]    rx_data,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [3:0]    mem_be,
  output logic [31:0]   mem_wdata,
  input  logic [31:0]   mem_rdata
);
  logic [AW-1:0]   desc_base;
  logic [AW-1:0]   stat_base;
  logic [IDXW-1:0] ring_last;
  logic [IDXW-1:0] cons;
  logic [IDXW-1:0] prod;
  logic            full;
  logic            adv;
  logic            drop_evt;
  logic [DCW-1:0]  drops;

  rxr_regs #(.AW(AW), .IDXW(IDXW), .DCW(DCW)) u_regs (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .prod(prod), .drops(drops),
    .desc_base(desc_base), .stat_base(stat_base), .ring_last(ring_last), .cons(cons)
  );

  rxr_ring #(.IDXW(IDXW), .DCW(DCW)) u_ring (
    .clk(clk), .rst(rst), .ring_last(ring_last), .cons(cons), .adv(adv),
    .drop_evt(drop_evt), .prod(prod), .full(full), .drops(drops)
  );

  rxr_writer #(.AW(AW), .IDXW(IDXW)) u_writer (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .rx_sof(rx_sof), .rx_eof(rx_eof), .rx_err(rx_err), .rx_data(rx_data),
    .desc_base(desc_base), .stat_base(stat_base), .prod(prod), .full(full),
    .adv(adv), .drop_evt(drop_evt), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  AST_ADV_AFTER_STATUS: assert property (@(posedge clk) disable iff (rst)
    (prod != $past(prod)) |->
      ($past(mem_req) && $past(mem_we) &&
       ($past(mem_addr) == stat_base + AW'({$past(prod), 3'b000}) + AW'(4)))); // R6
endmodule

// File: tb/rxring_engine_test.sv
`timescale 1ns/1ps
module rxring_engine_test;
  localparam int DESC = 32'h040;
  localparam int STAT = 32'h100;
  localparam int BUFB = 32'h200;
  localparam int NSLOT = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        rx_valid = 1'b0, rx_sof = 1'b0, rx_eof = 1'b0, rx_err = 1'b0;
  logic [7:0]  rx_data = '0;
  logic        rx_ready;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [3:0]  mem_be;

  logic [31:0] mem [0:1023];
  int checks = 0, fails = 0;
  int acc_cnt = 0, order_bad = 0, rd_n = 0;
  bit stat_seen = 0;
  logic [31:0] rd_log [0:3];

  always #2.5 clk = ~clk;

  rxring_engine uut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rx_valid(rx_valid),
    .rx_ready(rx_ready), .rx_sof(rx_sof), .rx_eof(rx_eof), .rx_err(rx_err),
    .rx_data(rx_data), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  always @(posedge clk) begin
    if (mem_req) begin
      if (mem_we) begin
        for (int b = 0; b < 4; b++)
          if (mem_be[b]) mem[mem_addr[11:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
      end else begin
        mem_rdata <= mem[mem_addr[11:2]];
      end
    end
  end

  always @(posedge clk) begin
    if (!rst && mem_req) begin
      acc_cnt++;
      if (!mem_we) begin
        if (rd_n < 4) rd_log[rd_n] = mem_addr;
        rd_n++;
      end else if (mem_addr >= STAT && mem_addr < STAT + 64) begin
        stat_seen = 1;
      end else if (stat_seen) begin
        order_bad++;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a;
    @(negedge clk); d = reg_rdata;
  endtask

  function automatic logic [7:0] byte_of(input int tag, input int i);
    return 8'((tag * 19 + i * 7 + 1) & 255);
  endfunction

  function automatic int cap_of(input int s);
    return 5 + 2 * s;
  endfunction

  task automatic send_frame(input int len, input int tag, input bit e_first, input bit e_last);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      rx_valid = 1; rx_data = byte_of(tag, i);
      rx_sof = (i == 0); rx_eof = (i == len - 1);
      rx_err = (i == 0 && e_first) || (i == len - 1 && e_last);
      while (!rx_ready) @(negedge clk);
      @(posedge clk);
    end
    @(negedge clk);
    rx_valid = 0; rx_sof = 0; rx_eof = 0; rx_err = 0;
  endtask

  task automatic wait_prod(input int exp, output logic [31:0] got);
    for (int t = 0; t < 100; t++) begin
      rd(3'd3, got);
      if (got == 32'(exp)) break;
    end
  endtask

  task automatic prefill(input int s);
    for (int w = 0; w < 16; w++) mem[(BUFB + 64 * s) / 4 + w] = 32'hA5A5_A5A5;
    mem[(STAT + 8 * s) / 4]     = 32'hFFFF_FFFF;
    mem[(STAT + 8 * s) / 4 + 1] = 32'hFFFF_FFFF;
  endtask

  task automatic check_slot(input int s, input int len, input int tag, input bit err, input string req);
    int stored, bad_k;
    logic [31:0] exp_info;
    logic [7:0] got_b, exp_b;
    stored = (len < cap_of(s)) ? len : cap_of(s);
    exp_info = 32'(stored - 1);
    if (err) exp_info[23] = 1'b1;
    if (len > cap_of(s)) exp_info[28] = 1'b1;
    chk(mem[(STAT + 8 * s) / 4] == exp_info, {req, " R5 status info"}, mem[(STAT + 8 * s) / 4], exp_info);
    chk(mem[(STAT + 8 * s) / 4 + 1] == 32'h0, "R5 second status word", mem[(STAT + 8 * s) / 4 + 1], 0);
    bad_k = -1;
    for (int k = 0; k < 64; k++) begin
      got_b = mem[(BUFB + 64 * s) / 4 + k / 4][8 * (k % 4) +: 8];
      exp_b = (k < stored) ? byte_of(tag, k) : 8'hA5;
      if (got_b != exp_b && bad_k < 0) bad_k = k;
    end
    chk(bad_k < 0, (len > cap_of(s)) ? "R4 buffer contents" : "R3 buffer contents", bad_k, -1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
    summary();
    $finish;
  end

  initial begin
    logic [31:0] v;
    for (int i = 0; i < 1024; i++) mem[i] = 32'h0;
    for (int s = 0; s < NSLOT; s++) begin
      mem[(DESC + 8 * s) / 4]     = BUFB + 64 * s;
      mem[(DESC + 8 * s) / 4 + 1] = 32'(cap_of(s) - 1) | 32'h0012_3800 | ((s % 2 == 1) ? 32'h8000_0000 : 32'h0);
    end
    repeat (4) @(posedge clk);
    @(negedge clk); rst = 0;

    chk(mem_req == 0 && rx_ready == 0, "R1 idle outputs", {mem_req, rx_ready}, 0);
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), v);
      chk(v == 0, "R1 register reset value", v, 0);
    end

    wr(3'd0, DESC); wr(3'd1, STAT); wr(3'd2, NSLOT - 1);
    rd(3'd0, v); chk(v == DESC, "R8 descriptor base readback", v, DESC);
    rd(3'd1, v); chk(v == STAT, "R8 status base readback", v, STAT);
    rd(3'd2, v); chk(v == NSLOT - 1, "R8 ring size readback", v, NSLOT - 1);
    wr(3'd3, 2); rd(3'd3, v); chk(v == 0, "R8 produce is read-only", v, 0);
    wr(3'd5, 7); rd(3'd5, v); chk(v == 0, "R8 drop count is read-only", v, 0);

    // near-exhaustive sweep: every length 1..13 through every slot
    for (int f = 0; f < 13 * NSLOT; f++) begin
      int s, len;
      bit e_first, e_last;
      s = f % NSLOT; len = 1 + f / NSLOT;
      e_last = (f % 3 == 0); e_first = (f % 5 == 1);
      prefill(s);
      rd_n = 0; stat_seen = 0; order_bad = 0;
      send_frame(len, f, e_first, e_last);
      wait_prod((f + 1) % NSLOT, v);
      chk(v == 32'((f + 1) % NSLOT), "R6 produce advance and wrap", v, (f + 1) % NSLOT);
      chk(rd_n == 2 && rd_log[0] == DESC + 8 * s && rd_log[1] == DESC + 8 * s + 4,
          "R2 descriptor fetch", rd_log[0], DESC + 8 * s);
      chk(order_bad == 0, "R6 status after data", order_bad, 0);
      check_slot(s, len, f, e_first || e_last, "sweep");
      wr(3'd4, (f + 1) % NSLOT);
    end

    // fill the ring: prod 0, cons 0 -> three frames fit
    for (int f = 0; f < NSLOT - 1; f++) begin
      prefill(f);
      send_frame(4, 100 + f, 0, 0);
      wait_prod(f + 1, v);
    end
    chk(v == NSLOT - 1, "R7 ring filled", v, NSLOT - 1);
    prefill(NSLOT - 1);
    acc_cnt = 0;
    send_frame(6, 200, 0, 0);
    repeat (5) @(negedge clk);
    chk(acc_cnt == 0, "R7 no memory access while full", acc_cnt, 0);
    rd(3'd5, v); chk(v == 1, "R7 drop counted", v, 1);
    rd(3'd3, v); chk(v == NSLOT - 1, "R7 produce unchanged", v, NSLOT - 1);
    chk(mem[(BUFB + 64 * (NSLOT - 1)) / 4] == 32'hA5A5_A5A5, "R7 buffer untouched",
        mem[(BUFB + 64 * (NSLOT - 1)) / 4], 32'hA5A5_A5A5);

    wr(3'd4, 1);
    send_frame(3, 300, 0, 1);
    wait_prod(0, v);
    chk(v == 0, "R9 frame accepted after consume", v, 0);
    check_slot(NSLOT - 1, 3, 300, 1, "R9");
    rd(3'd5, v); chk(v == 1, "R9 drop count stable", v, 1);

    summary();
    $finish;
  end
endmodule